// File: doc/BRIEF.md
# Status Word with Page-Based Address Mapping

This block holds the processor's 32-bit status word and, next to it, a small address mapper that turns a 20-bit logical word address into a 26-bit physical word address. The status word carries a 6-bit page number, six security flags, the four ALU condition flags (overflow, carry, zero, negative), an interrupt-enable bit and a 3-bit execution priority. Each field has its own set of writers. The ALU alone may change the condition flags. Only privileged software may change the page, security, enable and priority fields. The interrupt logic may clear the enable bit, or raise the priority to a granted level while setting the enable bit again.

The physical address is the current page number placed above the 20-bit logical address. The logical address cannot exceed 20 bits, so a process is confined to its page: 64 pages of 1M words each. A supervisor moves to another page by rewriting the page field. A software write issued outside privileged mode changes nothing and raises a violation pulse for one cycle.

Top module: `psr_mmu_top`

## Requirements
- R1: A synchronous active-high reset clears the whole status word to zero: page 0, interrupts disabled, priority 0, and no violation pulse.
- R2: Bits 31..22 and bits 5..4 of `status_o` always read zero, whatever value is written to them.
- R3: A software write with `priv_i`=1 loads bits 21..16 (page), 15..10 (security), 3 (interrupt enable) and 2..0 (priority) from `sw_wdata_i`. The new value is visible on the cycle after the write edge.
- R4: A software write never changes bits 9..6 (V, C, Z, N), whether or not it is privileged.
- R5: When `alu_we_i`=1, bits 9, 8, 7, 6 take `alu_flags_i[3]`, `[2]`, `[1]`, `[0]` (V, C, Z, N) on the next cycle, whatever the privilege, and also when a software write arrives in the same cycle.
- R6: A software write with `priv_i`=0 leaves every field unchanged, and `viol_o` is high for exactly the one cycle after that write edge.
- R7: `int_mask_i`=1 clears the interrupt-enable bit on the next cycle and leaves the priority as it is. It takes precedence over a software write to that bit.
- R8: `int_grant_i`=1 sets the priority to `int_level_i` and sets the interrupt-enable bit on the next cycle. It takes precedence over both `int_mask_i` and a software write.
- R9: `phys_addr_o` equals {page field, `log_addr_i`} combinationally, so it follows a change in `log_addr_i` within the same cycle.
- R10: `prio_o` and `ien_o` always equal bits 2..0 and bit 3 of `status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| priv_i | input | 1 | Current software runs in privileged mode |
| sw_we_i | input | 1 | Software write strobe for the status word |
| sw_wdata_i | input | 32 | Software write data |
| alu_we_i | input | 1 | ALU flag update strobe |
| alu_flags_i | input | 4 | New flags: [3]=V, [2]=C, [1]=Z, [0]=N |
| int_mask_i | input | 1 | Clear the interrupt-enable bit |
| int_grant_i | input | 1 | Enter a granted interrupt level |
| int_level_i | input | 3 | Priority of the granted interrupt |
| log_addr_i | input | 20 | Logical word address |
| status_o | output | 32 | Full status word |
| prio_o | output | 3 | Current execution priority |
| ien_o | output | 1 | Interrupt-enable bit |
| phys_addr_o | output | 26 | Physical word address |
| viol_o | output | 1 | One-cycle pulse after a rejected software write |

## Verification
Every update to the status word (software, ALU or interrupt) and the violation pulse pass through one register. They are therefore due on the first cycle after the edge that captured the request. The bench drives each stimulus on a falling edge, lets one rising edge pass, and samples status, priority, enable and violation on the next falling edge. The physical address has no register. It is checked in that same sample against the freshly updated page. A separate check changes only the logical address and samples shortly afterwards with no clock edge in between. The cycle after each rejected write is inspected as well, to confirm that the violation pulse has already dropped.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int WORD_W   = 32;
    localparam int PAGE_W   = 6;
    localparam int LADDR_W  = 20;
    localparam int SEC_W    = 6;
    localparam int PRIO_W   = 3;
    localparam int FLAG_W   = 4;
    localparam int RSVLO_W  = 2;
    localparam int PADDR_W  = PAGE_W + LADDR_W;
    localparam int RSVHI_W  = WORD_W - PAGE_W - SEC_W - FLAG_W - RSVLO_W - 1 - PRIO_W;

    typedef struct packed {
        logic v;
        logic c;
        logic z;
        logic n;
    } alu_flags_t;

    typedef struct packed {
        logic [RSVHI_W-1:0] rsv_hi;
        logic [PAGE_W-1:0]  page;
        logic [SEC_W-1:0]   sec;
        alu_flags_t         flags;
        logic [RSVLO_W-1:0] rsv_lo;
        logic               ien;
        logic [PRIO_W-1:0]  prio;
    } psr_t;

    // Fields owned by privileged software and the interrupt logic
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SEC_W-1:0]  sec;
        logic              ien;
        logic [PRIO_W-1:0] prio;
    } os_fields_t;

    function automatic os_fields_t os_extract(psr_t s);
        os_fields_t o;
        o.page = s.page;
        o.sec  = s.sec;
        o.ien  = s.ien;
        o.prio = s.prio;
        return o;
    endfunction

    function automatic psr_t psr_compose(os_fields_t o, alu_flags_t f);
        psr_t s;
        s.rsv_hi = '0;
        s.page   = o.page;
        s.sec    = o.sec;
        s.flags  = f;
        s.rsv_lo = '0;
        s.ien    = o.ien;
        s.prio   = o.prio;
        return s;
    endfunction

endpackage

// File: rtl/psr_write_guard.sv
module psr_write_guard
    import psr_pkg::*;
(
    input  logic              priv_i,
    input  logic              sw_we_i,
    input  logic [WORD_W-1:0] sw_wdata_i,
    input  os_fields_t        cur_i,
    output os_fields_t        next_o,
    output logic              viol_o
);
    psr_t wr_view;

    always_comb begin
        wr_view = psr_t'(sw_wdata_i);
        next_o  = cur_i;
        viol_o  = 1'b0;
        if (sw_we_i) begin
            if (priv_i) begin
                next_o = os_extract(wr_view);
            end else begin
                viol_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/psr_irq_ctl.sv
module psr_irq_ctl
    import psr_pkg::*;
(
    input  os_fields_t        in_i,
    input  logic              int_mask_i,
    input  logic              int_grant_i,
    input  logic [PRIO_W-1:0] int_level_i,
    output os_fields_t        out_o
);
    always_comb begin
        out_o = in_i;
        if (int_grant_i) begin
            out_o.prio = int_level_i;
            out_o.ien  = 1'b1;
        end else if (int_mask_i) begin
            out_o.ien  = 1'b0;
        end
    end
endmodule

// File: rtl/psr_flag_unit.sv
module psr_flag_unit
    import psr_pkg::*;
(
    input  alu_flags_t        cur_i,
    input  logic              alu_we_i,
    input  logic [FLAG_W-1:0] alu_flags_i,
    output alu_flags_t        next_o
);
    always_comb begin
        next_o = alu_we_i ? alu_flags_t'(alu_flags_i) : cur_i;
    end
endmodule

// File: rtl/psr_page_map.sv
module psr_page_map #(
    parameter int PG_W = 6,
    parameter int LA_W = 20,
    localparam int PA_W = PG_W + LA_W
) (
    input  logic [PG_W-1:0] page_i,
    input  logic [LA_W-1:0] laddr_i,
    output logic [PA_W-1:0] paddr_o
);
    always_comb begin
        paddr_o = {page_i, laddr_i};
    end
endmodule

// File: rtl/psr_mmu_top.sv
module psr_mmu_top
    import psr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               priv_i,
    input  logic               sw_we_i,
    input  logic [WORD_W-1:0]  sw_wdata_i,
    input  logic               alu_we_i,
    input  logic [FLAG_W-1:0]  alu_flags_i,
    input  logic               int_mask_i,
    input  logic               int_grant_i,
    input  logic [PRIO_W-1:0]  int_level_i,
    input  logic [LADDR_W-1:0] log_addr_i,
    output logic [WORD_W-1:0]  status_o,
    output logic [PRIO_W-1:0]  prio_o,
    output logic               ien_o,
    output logic [PADDR_W-1:0] phys_addr_o,
    output logic               viol_o
);
    psr_t       psr_q;
    psr_t       psr_d;
    logic       viol_q;
    logic       viol_d;
    os_fields_t os_sw;
    os_fields_t os_next;
    alu_flags_t flags_next;

    psr_write_guard u_guard (
        .priv_i     (priv_i),
        .sw_we_i    (sw_we_i),
        .sw_wdata_i (sw_wdata_i),
        .cur_i      (os_extract(psr_q)),
        .next_o     (os_sw),
        .viol_o     (viol_d)
    );

    psr_irq_ctl u_irq (
        .in_i        (os_sw),
        .int_mask_i  (int_mask_i),
        .int_grant_i (int_grant_i),
        .int_level_i (int_level_i),
        .out_o       (os_next)
    );

    psr_flag_unit u_flags (
        .cur_i       (psr_q.flags),
        .alu_we_i    (alu_we_i),
        .alu_flags_i (alu_flags_i),
        .next_o      (flags_next)
    );

    always_comb begin
        psr_d = psr_compose(os_next, flags_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psr_q  <= '0;
            viol_q <= 1'b0;
        end else begin
            psr_q  <= psr_d;
            viol_q <= viol_d;
        end
    end

    psr_page_map #(
        .PG_W (PAGE_W),
        .LA_W (LADDR_W)
    ) u_map (
        .page_i  (psr_q.page),
        .laddr_i (log_addr_i),
        .paddr_o (phys_addr_o)
    );

    assign status_o = psr_q;
    assign prio_o   = psr_q.prio;
    assign ien_o    = psr_q.ien;
    assign viol_o   = viol_q;
endmodule

// File: rtl/psr_mmu_chk.sv
module psr_mmu_chk
    import psr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               priv_i,
    input logic               sw_we_i,
    input logic               alu_we_i,
    input logic               int_mask_i,
    input logic               int_grant_i,
    input logic [PRIO_W-1:0]  int_level_i,
    input logic [LADDR_W-1:0] log_addr_i,
    input logic [WORD_W-1:0]  status_o,
    input logic [PRIO_W-1:0]  prio_o,
    input logic               ien_o,
    input logic [PADDR_W-1:0] phys_addr_o,
    input logic               viol_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (status_o == '0 && !viol_o));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (status_o[31:22] == '0 && status_o[5:4] == '0));

    a_r4_flags_alu_only: assert property (@(posedge clk) disable iff (rst)
        !alu_we_i |=> $stable(status_o[9:6]));

    a_r6_user_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (sw_we_i && !priv_i && !alu_we_i && !int_mask_i && !int_grant_i)
        |=> ($stable(status_o) && viol_o));

    a_r6_viol_cause: assert property (@(posedge clk) disable iff (rst)
        !(sw_we_i && !priv_i) |=> !viol_o);

    a_r7_mask_clears: assert property (@(posedge clk) disable iff (rst)
        (int_mask_i && !int_grant_i) |=> (!ien_o && $stable(prio_o)));

    a_r8_grant_level: assert property (@(posedge clk) disable iff (rst)
        int_grant_i |=> (ien_o && prio_o == $past(int_level_i)));

    a_r9_page_concat: assert property (@(posedge clk) disable iff (rst)
        phys_addr_o == {status_o[21:16], log_addr_i});

    a_r10_mirrors: assert property (@(posedge clk) disable iff (rst)
        (prio_o == status_o[2:0] && ien_o == status_o[3]));
endmodule

bind psr_mmu_top psr_mmu_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .priv_i      (priv_i),
    .sw_we_i     (sw_we_i),
    .alu_we_i    (alu_we_i),
    .int_mask_i  (int_mask_i),
    .int_grant_i (int_grant_i),
    .int_level_i (int_level_i),
    .log_addr_i  (log_addr_i),
    .status_o    (status_o),
    .prio_o      (prio_o),
    .ien_o       (ien_o),
    .phys_addr_o (phys_addr_o),
    .viol_o      (viol_o)
);

// File: tb/psr_mmu_top_bench.sv
module psr_mmu_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        priv_i;
    logic        sw_we_i;
    logic [31:0] sw_wdata_i;
    logic        alu_we_i;
    logic [3:0]  alu_flags_i;
    logic        int_mask_i;
    logic        int_grant_i;
    logic [2:0]  int_level_i;
    logic [19:0] log_addr_i;
    logic [31:0] status_o;
    logic [2:0]  prio_o;
    logic        ien_o;
    logic [25:0] phys_addr_o;
    logic        viol_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    psr_mmu_top u_psr_mmu_top (
        .clk         (clk),
        .rst         (rst),
        .priv_i      (priv_i),
        .sw_we_i     (sw_we_i),
        .sw_wdata_i  (sw_wdata_i),
        .alu_we_i    (alu_we_i),
        .alu_flags_i (alu_flags_i),
        .int_mask_i  (int_mask_i),
        .int_grant_i (int_grant_i),
        .int_level_i (int_level_i),
        .log_addr_i  (log_addr_i),
        .status_o    (status_o),
        .prio_o      (prio_o),
        .ien_o       (ien_o),
        .phys_addr_o (phys_addr_o),
        .viol_o      (viol_o)
    );

    typedef struct packed {
        logic        priv;
        logic        we;
        logic [31:0] wdata;
        logic        alu;
        logic [3:0]  fl;
        logic        msk;
        logic        gr;
        logic [2:0]  lvl;
        logic [19:0] la;
        logic [31:0] est;
        logic        ev;
        logic [25:0] ep;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        // R3: privileged write of all ones, reserved bits dropped (R2)
        '{1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 4'h0, 1'b0, 1'b0, 3'd0, 20'h12345, 32'h003F_FC0F, 1'b0, 26'h3F1_2345},
        // R6: user write ignored, violation pulse
        '{1'b0, 1'b1, 32'h0000_0000, 1'b0, 4'h0, 1'b0, 1'b0, 3'd0, 20'hFFFFF, 32'h003F_FC0F, 1'b1, 26'h3FF_FFFF},
        // R5: ALU sets V and Z
        '{1'b0, 1'b0, 32'h0000_0000, 1'b1, 4'hA, 1'b0, 1'b0, 3'd0, 20'h00000, 32'h003F_FE8F, 1'b0, 26'h3F0_0000},
        // R4 R5: software tries flag bits while ALU writes C and N
        '{1'b1, 1'b1, 32'h0000_03C0, 1'b1, 4'h5, 1'b0, 1'b0, 3'd0, 20'h00ABC, 32'h0000_0140, 1'b0, 26'h000_0ABC},
        // R3 R9: page 5, enable on, priority 1
        '{1'b1, 1'b1, 32'h0005_0009, 1'b0, 4'h0, 1'b0, 1'b0, 3'd0, 20'h7FFFF, 32'h0005_0149, 1'b0, 26'h057_FFFF},
        // R7: mask clears enable, priority kept
        '{1'b0, 1'b0, 32'h0000_0000, 1'b0, 4'h0, 1'b1, 1'b0, 3'd0, 20'h00001, 32'h0005_0141, 1'b0, 26'h050_0001},
        // R8: grant overrides a same-cycle privileged write on enable/priority
        '{1'b1, 1'b1, 32'h0000_0000, 1'b0, 4'h0, 1'b0, 1'b1, 3'd6, 20'h00010, 32'h0000_014E, 1'b0, 26'h000_0010},
        // R8: grant wins over mask
        '{1'b0, 1'b0, 32'h0000_0000, 1'b0, 4'h0, 1'b1, 1'b1, 3'd2, 20'h00002, 32'h0000_014A, 1'b0, 26'h000_0002},
        // R5 R6: user write rejected while ALU clears flags
        '{1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 4'h0, 1'b0, 1'b0, 3'd0, 20'h00003, 32'h0000_000A, 1'b1, 26'h000_0003},
        // R2: write only reserved bits
        '{1'b1, 1'b1, 32'hFFC0_0030, 1'b0, 4'h0, 1'b0, 1'b0, 3'd0, 20'h55555, 32'h0000_0000, 1'b0, 26'h005_5555},
        // R3 R9: page 1 at top of logical space
        '{1'b1, 1'b1, 32'h0001_0000, 1'b0, 4'h0, 1'b0, 1'b0, 3'd0, 20'hFFFFF, 32'h0001_0000, 1'b0, 26'h01F_FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        priv_i      = 1'b0;
        sw_we_i     = 1'b0;
        sw_wdata_i  = '0;
        alu_we_i    = 1'b0;
        alu_flags_i = '0;
        int_mask_i  = 1'b0;
        int_grant_i = 1'b0;
        int_level_i = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        log_addr_i = 20'h00042;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 status", status_o, 32'h0);
        check("R1 viol", {31'd0, viol_o}, 32'd0);
        check("R1 prio/ien", {28'd0, ien_o, prio_o}, 32'd0);
        check("R9 page0", {6'd0, phys_addr_o}, 32'h0000_0042);

        for (int i = 0; i < NVEC; i++) begin
            priv_i      = VEC[i].priv;
            sw_we_i     = VEC[i].we;
            sw_wdata_i  = VEC[i].wdata;
            alu_we_i    = VEC[i].alu;
            alu_flags_i = VEC[i].fl;
            int_mask_i  = VEC[i].msk;
            int_grant_i = VEC[i].gr;
            int_level_i = VEC[i].lvl;
            log_addr_i  = VEC[i].la;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R3-vec%0d status", i), status_o, VEC[i].est);
            check($sformatf("R6 vec%0d viol", i), {31'd0, viol_o}, {31'd0, VEC[i].ev});
            check($sformatf("R9 vec%0d phys", i), {6'd0, phys_addr_o}, {6'd0, VEC[i].ep});
            check($sformatf("R10 vec%0d mirrors", i), {28'd0, ien_o, prio_o}, {28'd0, VEC[i].est[3:0]});
            check($sformatf("R2 vec%0d reserved", i), {status_o[31:22], status_o[5:4]}, 32'd0);
        end

        // R6: pulse lasts a single cycle
        idle_inputs();
        priv_i = 1'b0; sw_we_i = 1'b1; sw_wdata_i = 32'h0000_0000;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check("R6 pulse high", {31'd0, viol_o}, 32'd1);
        check("R6 state held", status_o, 32'h0001_0000);
        @(posedge clk);
        @(negedge clk);
        check("R6 pulse gone", {31'd0, viol_o}, 32'd0);

        // R9: address follows logical input without a clock edge
        log_addr_i = 20'hABCDE;
        #1;
        check("R9 combinational", {6'd0, phys_addr_o}, 32'h01A_BCDE);

        // R4: privileged write of flag bits alone leaves flags clear
        priv_i = 1'b1; sw_we_i = 1'b1; sw_wdata_i = 32'h0001_03C0;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check("R4 flags untouched", status_o, 32'h0001_0000);

        // R1: mid-run reset with concurrent activity
        priv_i = 1'b1; sw_we_i = 1'b1; sw_wdata_i = 32'h0007_000F;
        alu_we_i = 1'b1; alu_flags_i = 4'hF; int_grant_i = 1'b1; int_level_i = 3'd5;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle_inputs();
        check("R1 midrun status", status_o, 32'h0);
        check("R1 midrun viol", {31'd0, viol_o}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule